// File: doc/BRIEF.md
# DMA Channel Control and Request Arbitration Registers

This block is the control half of a four-channel DMA engine. It takes byte writes to eight control offsets and keeps a command byte, a per-channel mask, a per-channel mode setting and an 8-bit status byte. The upper half of the status byte holds one pending-request flag per channel. The lower half holds one terminal-count flag per channel. Requests come from two sources, and both drive the same flags: peripherals assert hold and release strobes, and software writes the request offset.

A combinational scan then looks at every channel whose mask bit is clear and whose request flag is set. It raises a grant for each such channel and a single one-hot winner, with channel 0 first. Because the scan reads the registers directly, a change to the mask or to a request shows on the grant outputs as soon as the register has taken it. The mode settings are decoded into transfer type, auto-initialise and address-decrement outputs that the address section uses. Address and count registers are not part of this block.

Top module: `dma_ctl_regs`

## Requirements
- R1: A write to offset 0 loads the command byte from the data bus. Offsets 0 to 7 decode, in order, to: command, request, single mask, mode, byte-pointer clear, master clear, clear all masks, write all masks.
- R2: A request write (offset 1) selects a channel with data bits 1:0. It sets that channel's request flag (status bit channel+4) when data bit 2 is 1 and clears it when data bit 2 is 0. It also clears that channel's terminal-count flag (status bit channel).
- R3: A single-mask write (offset 2) sets the mask bit of the channel given by data bits 1:0 when data bit 2 is 1, and clears it when data bit 2 is 0. The other mask bits are unchanged.
- R4: A clear-all-masks write (offset 6) makes the mask 0. A write-all-masks write (offset 7) loads the mask from data bits 3:0.
- R5: A hw_hold bit sets that channel's request flag and a hw_release bit clears it. These strobes override a software request write in the same cycle, and a release overrides a hold.
- R6: A tc_in bit sets that channel's terminal-count flag, even when a request write clears that flag in the same cycle.
- R7: grant bit c is 1 exactly when mask bit c is 0 and request flag c is 1. top_grant is the one-hot of the lowest-numbered granted channel, or 0 when nothing is granted. Both follow the registers in the same cycle.
- R8: A mode write (offset 3) stores a mode for the channel given by data bits 1:0. Data bits 3:2 appear on xfer_type[2c+1:2c], bit 4 on autoinit[c] and bit 5 on decrement[c]. Other channels keep their modes.
- R9: A master clear (offset 5) zeroes the command, status and byte pointer and sets all four mask bits. It overrides hardware strobes in the same cycle and leaves the modes unchanged. Reset has the same effect as a master clear and also zeroes all modes.
- R10: byte_ptr toggles on each ff_toggle strobe. A byte-pointer clear (offset 4) or a master clear forces it to 0 and wins over a toggle in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control write strobe |
| wr_addr | input | 3 | Control offset |
| wr_data | input | 8 | Write data |
| hw_hold | input | 4 | Per-channel hardware request raise strobes |
| hw_release | input | 4 | Per-channel hardware request drop strobes |
| tc_in | input | 4 | Per-channel terminal-count strobes |
| ff_toggle | input | 1 | Byte pointer toggle from the address section |
| command | output | 8 | Command byte |
| status | output | 8 | Request flags 7:4, terminal-count flags 3:0 |
| mask | output | 4 | Channel mask, 1 = masked |
| byte_ptr | output | 1 | Low/high byte pointer |
| grant | output | 4 | Unmasked channels with a pending request |
| top_grant | output | 4 | Highest-priority granted channel, one-hot |
| xfer_type | output | 8 | Two-bit transfer type per channel |
| autoinit | output | 4 | Auto-initialise enable per channel |
| decrement | output | 4 | Address-decrement select per channel |

## Verification
Every register result (command, status, mask, byte pointer, modes) is due at the first rising edge after the stimulus is applied. The grant outputs add no further cycle, because they are combinational from those registers. The bench applies each stimulus at a falling edge and returns the inputs to idle at the next falling edge. It compares all results at that falling edge, so one rising edge lies between drive and sample, and the idle inputs cannot move any register before the comparison. A table of vectors covers the request, mask, strobe-conflict and priority paths. Directed tests cover the command and mode decode, the byte pointer, master clear and reset.

// File: rtl/dma_ctl_regs.sv
module dma_ctl_regs #(
  parameter int NCH = 4,
  parameter int DW  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [NCH-1:0]   hw_hold,
  input  logic [NCH-1:0]   hw_release,
  input  logic [NCH-1:0]   tc_in,
  input  logic             ff_toggle,
  output logic [DW-1:0]    command,
  output logic [2*NCH-1:0] status,
  output logic [NCH-1:0]   mask,
  output logic             byte_ptr,
  output logic [NCH-1:0]   grant,
  output logic [NCH-1:0]   top_grant,
  output logic [2*NCH-1:0] xfer_type,
  output logic [NCH-1:0]   autoinit,
  output logic [NCH-1:0]   decrement
);
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [2:0] OFF_CMD = 3'd0, OFF_REQ = 3'd1, OFF_SMASK = 3'd2,
                         OFF_MODE = 3'd3, OFF_CLRFF = 3'd4, OFF_MCLR = 3'd5,
                         OFF_CLRALL = 3'd6, OFF_WRALL = 3'd7;

  logic [DW-1:0]  cmd_q;
  logic [NCH-1:0] req_q, tc_q, mask_q, req_d, tc_d, mask_d;
  logic           ff_q;
  logic [3:0]     mode_q [NCH];

  wire [CW-1:0] sel    = wr_data[CW-1:0];
  wire          bit2   = wr_data[2];
  wire          we_cmd = wr_en && wr_addr == OFF_CMD;
  wire          we_req = wr_en && wr_addr == OFF_REQ;
  wire          we_sm  = wr_en && wr_addr == OFF_SMASK;
  wire          we_md  = wr_en && wr_addr == OFF_MODE;
  wire          we_cf  = wr_en && wr_addr == OFF_CLRFF;
  wire          mclr   = wr_en && wr_addr == OFF_MCLR;
  wire          we_ca  = wr_en && wr_addr == OFF_CLRALL;
  wire          we_wa  = wr_en && wr_addr == OFF_WRALL;

  always_comb begin
    req_d  = req_q;
    tc_d   = tc_q;
    mask_d = mask_q;
    if (we_ca) mask_d = '0;
    if (we_wa) mask_d = wr_data[NCH-1:0];
    for (int c = 0; c < NCH; c++) begin
      if (we_req && sel == CW'(c)) begin
        req_d[c] = bit2;
        tc_d[c]  = 1'b0;
      end
      if (we_sm && sel == CW'(c)) mask_d[c] = bit2;
    end
    req_d = (req_d | hw_hold) & ~hw_release;
    tc_d  = tc_d | tc_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || mclr) begin
      cmd_q  <= '0;
      req_q  <= '0;
      tc_q   <= '0;
      mask_q <= '1;
    end else begin
      if (we_cmd) cmd_q <= wr_data;
      req_q  <= req_d;
      tc_q   <= tc_d;
      mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || mclr || we_cf) ff_q <= 1'b0;
    else if (ff_toggle)          ff_q <= ~ff_q;
  end

  always_ff @(posedge clk) begin
    for (int c = 0; c < NCH; c++) begin
      if (!rst_n) mode_q[c] <= '0;
      else if (we_md && sel == CW'(c)) mode_q[c] <= wr_data[5:2];
    end
  end

  always_comb begin
    top_grant = '0;
    for (int c = NCH - 1; c >= 0; c--)
      if (grant[c]) top_grant = NCH'(1) << c;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_mode
    assign xfer_type[2*c +: 2] = mode_q[c][1:0];
    assign autoinit[c]         = mode_q[c][2];
    assign decrement[c]        = mode_q[c][3];
  end

  assign grant    = ~mask_q & req_q;
  assign command  = cmd_q;
  assign status   = {req_q, tc_q};
  assign mask     = mask_q;
  assign byte_ptr = ff_q;

  p_mclr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mclr |=> (status == '0 && mask == '1 && command == '0 && !byte_ptr));

  p_clrall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (we_ca && !mclr) |=> mask == '0);

  p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_release) |=> (status[2*NCH-1:NCH] & $past(hw_release)) == '0);

  p_tc_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|tc_in && !mclr) |=> (status[NCH-1:0] & $past(tc_in)) == $past(tc_in));

  p_onehot_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(top_grant) && (top_grant & mask) == '0);

  p_ff_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    we_cf |=> !byte_ptr);
endmodule

// File: tb/tb_dma_ctl_regs.sv
`timescale 1ns/1ps
module tb_dma_ctl_regs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] hw_hold = '0, hw_release = '0, tc_in = '0;
  logic       ff_toggle = 1'b0;
  logic [7:0] command, status, xfer_type;
  logic [3:0] mask, grant, top_grant, autoinit, decrement;
  logic       byte_ptr;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dma_ctl_regs dut (.clk, .rst_n, .wr_en, .wr_addr, .wr_data, .hw_hold,
    .hw_release, .tc_in, .ff_toggle, .command, .status, .mask, .byte_ptr,
    .grant, .top_grant, .xfer_type, .autoinit, .decrement);

  typedef struct packed {
    logic       we;
    logic [2:0] a;
    logic [7:0] d;
    logic [3:0] h, r, t;
    logic [7:0] es;
    logic [3:0] em, eg, et;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{1, 3'd7, 8'h00, 4'h0, 4'h0, 4'h0, 8'h00, 4'h0, 4'h0, 4'h0}, // R4 write-all 0
    '{1, 3'd1, 8'h06, 4'h0, 4'h0, 4'h0, 8'h40, 4'h0, 4'h4, 4'h4}, // R2 sw req ch2, R7
    '{0, 3'd0, 8'h00, 4'h2, 4'h0, 4'h0, 8'h60, 4'h0, 4'h6, 4'h2}, // R5 hold ch1, R7 priority
    '{1, 3'd2, 8'h05, 4'h0, 4'h0, 4'h0, 8'h60, 4'h2, 4'h4, 4'h4}, // R3 mask ch1
    '{0, 3'd0, 8'h00, 4'h0, 4'h0, 4'h4, 8'h64, 4'h2, 4'h4, 4'h4}, // R6 tc ch2
    '{1, 3'd1, 8'h02, 4'h0, 4'h0, 4'h0, 8'h20, 4'h2, 4'h0, 4'h0}, // R2 drop ch2, tc cleared
    '{1, 3'd7, 8'h0E, 4'h1, 4'h0, 4'h0, 8'h30, 4'hE, 4'h1, 4'h1}, // R4 write-all, R5 hold ch0
    '{1, 3'd1, 8'h04, 4'h8, 4'h1, 4'h0, 8'hA0, 4'hE, 4'h0, 4'h0}, // R5 release beats sw req
    '{1, 3'd6, 8'h00, 4'h0, 4'h0, 4'h0, 8'hA0, 4'h0, 4'hA, 4'h2}, // R4 clear-all, R7
    '{1, 3'd1, 8'h03, 4'h0, 4'h0, 4'h8, 8'h28, 4'h0, 4'h2, 4'h2}, // R6 tc beats req clear
    '{1, 3'd2, 8'h04, 4'h0, 4'h0, 4'h0, 8'h28, 4'h1, 4'h2, 4'h2}, // R3 mask ch0
    '{1, 3'd5, 8'h00, 4'hF, 4'h0, 4'h0, 8'h00, 4'hF, 4'h0, 4'h0}  // R9 mclr beats hold
  };

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic drive(logic we, logic [2:0] a, logic [7:0] d,
                       logic [3:0] h, logic [3:0] r, logic [3:0] t, logic tg);
    wr_en = we; wr_addr = a; wr_data = d;
    hw_hold = h; hw_release = r; tc_in = t; ff_toggle = tg;
    @(negedge clk);
    wr_en = 0; wr_addr = '0; wr_data = '0;
    hw_hold = '0; hw_release = '0; tc_in = '0; ff_toggle = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #100000;
    n_fail++;
    n_run++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check("R9 reset status", status, 8'h00);
    check("R9 reset mask", mask, 4'hF);
    check("R9 reset command", command, 8'h00);
    check("R9 reset byte_ptr", byte_ptr, 1'b0);
    check("R9 reset modes", {xfer_type, autoinit, decrement}, 16'h0);

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i].we, TBL[i].a, TBL[i].d, TBL[i].h, TBL[i].r, TBL[i].t, 1'b0);
      check($sformatf("vec%0d status R2 R5 R6", i), status, TBL[i].es);
      check($sformatf("vec%0d mask R3 R4", i), mask, TBL[i].em);
      check($sformatf("vec%0d grant R7", i), grant, TBL[i].eg);
      check($sformatf("vec%0d top_grant R7", i), top_grant, TBL[i].et);
    end

    // R1 command decode
    drive(1, 3'd0, 8'hA5, 0, 0, 0, 0);
    check("R1 command", command, 8'hA5);
    check("R1 mask untouched", mask, 4'hF);

    // R8 mode decode
    drive(1, 3'd3, 8'h3A, 0, 0, 0, 0);
    check("R8 ch2 type", xfer_type, 8'h20);
    check("R8 ch2 autoinit", autoinit, 4'h4);
    check("R8 ch2 decrement", decrement, 4'h4);
    drive(1, 3'd3, 8'h04, 0, 0, 0, 0);
    check("R8 ch0 type, ch2 kept", xfer_type, 8'h21);
    check("R8 ch0 autoinit kept", autoinit, 4'h4);

    // R10 byte pointer
    drive(0, 3'd0, 8'h00, 0, 0, 0, 1);
    check("R10 toggle", byte_ptr, 1'b1);
    drive(1, 3'd4, 8'h00, 0, 0, 0, 1);
    check("R10 clear beats toggle", byte_ptr, 1'b0);
    drive(0, 3'd0, 8'h00, 0, 0, 0, 1);
    check("R10 toggle again", byte_ptr, 1'b1);

    // R9 master clear keeps modes, clears the rest
    drive(1, 3'd6, 8'h00, 4'h3, 0, 4'h5, 0);
    check("R9 pre-mclr grant", grant, 4'h3);
    drive(1, 3'd5, 8'h00, 0, 0, 0, 1);
    check("R9 mclr status", status, 8'h00);
    check("R9 mclr mask", mask, 4'hF);
    check("R9 mclr command", command, 8'h00);
    check("R9 mclr byte_ptr", byte_ptr, 1'b0);
    check("R9 mclr keeps modes", xfer_type, 8'h21);
    check("R9 mclr keeps autoinit", autoinit, 4'h4);

    // R9 reset zeroes modes
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 reset clears modes", {xfer_type, autoinit, decrement}, 16'h0);
    check("R9 reset mask again", mask, 4'hF);

    finish_run();
  end
endmodule